// File: doc/BRIEF.md
# Feed-Sequence Watchdog Timer

This block guards against software that has stopped making progress. A 32-bit down counter runs off a fixed divide-by-4 prescaler. Software starts it by setting an enable bit and then proving it is alive with a two-write feed sequence. Each valid feed reloads the counter from a reload register. The counter expires when it reaches zero. The block also treats a malformed feed sequence as a fault while it is enabled. Either fault is turned into a one-cycle reset request or a level interrupt, chosen by a mode bit.

Software can set the enable bit but cannot clear it. Only the hardware reset `rst_ni` or the block's own fault event disables the watchdog again. A sticky flag records that a watchdog reset request was issued. The flag survives the fault, so the firmware can read it after the system restarts. It is cleared only by software or by `rst_ni`.

The register port is a single-cycle write/read interface with a 2-bit address. The read data is combinational from the address. A read strobe marks a read access, because any access counts when the feed sequence is being checked.

Top module: `wdog_feed_top`

## Requirements
- R1: After `rst_ni` is released, control (address 0) reads 0, reload (address 1) reads 256, count (address 3) reads 0, and `rst_req_o` and `irq_o` are low.
- R2: Control bit 0 (enable) is set by writing 1 to it. Writing 0 to it has no effect, so the enable stays set until a fault event or `rst_ni` clears it.
- R3: A write to reload (address 1) stores the written value, except that values below 256 are stored as 256.
- R4: A valid feed is a write of 0xAA to address 2 followed by a write of 0x55 to address 2. Only bits 7:0 of the write data are compared. Idle cycles may separate the two writes, but no other access may. While the block is enabled, a valid feed loads the count from the reload register and restarts the prescaler. The count does not change after enabling until the first valid feed.
- R5: If no further feed arrives, a fault event occurs exactly 4*N clock edges after the edge that completed a feed with reload value N. The count decrements once every 4 cycles.
- R6: A fault event with control bit 1 (mode) set drives `rst_req_o` high for exactly one cycle, sets control bit 3 (watchdog-reset flag) and clears enable.
- R7: A fault event with mode clear sets control bit 2 (interrupt flag), which drives `irq_o`, and clears enable. Writing 0 to bit 2 clears the flag.
- R8: While the block is enabled, each of these is a fault event at the edge of the offending access: a write to address 2 that is neither 0xAA nor a 0x55 completing a sequence, or any other access that follows a pending 0xAA.
- R9: While the block is disabled, feed writes neither load the count nor raise `rst_req_o` or `irq_o`.
- R10: The watchdog-reset flag is cleared only by a control write with bit 3 equal to 0, or by `rst_ni`. Writing 1 to bit 3 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (marks an access) |
| reg_addr_i | input | 2 | Register address: 0 control, 1 reload, 2 feed, 3 count |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| rst_req_o | output | 1 | One-cycle watchdog reset request |
| irq_o | output | 1 | Watchdog interrupt (level) |

## Verification
Some faults live only in internal state: a stale pending-0xAA bit, a prescaler phase off by one, or an armed flag that failed to clear. Such faults first reach the ports as a fault event on the wrong edge. A behavioural model tracks every cycle and compares `rst_req_o` and `irq_o` on each edge, so a shifted event shows up within one cycle of when it should have occurred. The count is read back directly a few cycles after feeds. This exposes a load from the wrong source or a missing clamp long before the 1200-cycle timeout would.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_LOAD  = 2'd1,
    A_FEED  = 2'd2,
    A_COUNT = 2'd3
  } wd_addr_e;

  localparam int unsigned C_EN   = 0;
  localparam int unsigned C_MODE = 1;
  localparam int unsigned C_IRQ  = 2;
  localparam int unsigned C_WDF  = 3;
  localparam int unsigned C_BITS = 4;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      logic unused_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) unused_q <= 1'b0;
        else         unused_q <= clr_i;
      end
      assign tick_o = run_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] ph_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              ph_q <= '0;
        else if (clr_i || !run_i) ph_q <= '0;
        else if (ph_q == LAST)    ph_q <= '0;
        else                      ph_q <= ph_q + 1'b1;
      end
      assign tick_o = run_i && (ph_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq #(
  parameter int unsigned KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_A = 8'hAA,
  parameter logic [KEY_W-1:0] KEY_B = 8'h55
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             feed_wr_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             good_o,
  output logic             bad_o
);
  logic pend_q, pend_d;

  always_comb begin
    good_o = 1'b0;
    bad_o  = 1'b0;
    pend_d = pend_q;
    if (acc_i) begin
      if (feed_wr_i) begin
        if (pend_q) begin
          pend_d = 1'b0;
          if (key_i == KEY_B) good_o = 1'b1;
          else                bad_o  = 1'b1;
        end else if (key_i == KEY_A) begin
          pend_d = 1'b1;
        end else begin
          bad_o = 1'b1;
        end
      end else begin
        // any foreign access breaks an open sequence
        bad_o  = pend_q;
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             kill_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             armed_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (load_i && !kill_i) cnt_q <= reload_i;
      else if (tick_i)       cnt_q <= cnt_q - 1'b1;

      if (kill_i)      armed_q <= 1'b0;
      else if (load_i) armed_q <= 1'b1;
    end
  end

  assign expire_o = armed_q && tick_i && (cnt_q == ONE);
  assign cnt_o    = cnt_q;
  assign armed_o  = armed_q;
endmodule

// File: rtl/wdog_feed_top.sv
module wdog_feed_top
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned MIN_LOAD = 256,
  parameter int unsigned KEY_W    = 8,
  parameter logic [KEY_W-1:0] KEY_A = 8'hAA,
  parameter logic [KEY_W-1:0] KEY_B = 8'h55
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  output logic             rst_req_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] MIN_VAL = CNT_W'(MIN_LOAD);

  wd_addr_e addr;
  logic acc, feed_wr, ctrl_wr, load_wr;
  logic good, bad, tick, expire, armed, ev;
  logic [CNT_W-1:0] cnt;

  logic en_q, mode_q, irq_q, wdf_q, rst_req_q;
  logic [CNT_W-1:0] reload_q;

  assign addr    = wd_addr_e'(reg_addr_i);
  assign acc     = reg_we_i || reg_re_i;
  assign feed_wr = reg_we_i && (addr == A_FEED);
  assign ctrl_wr = reg_we_i && (addr == A_CTRL);
  assign load_wr = reg_we_i && (addr == A_LOAD);

  wdog_feed_seq #(
    .KEY_W (KEY_W),
    .KEY_A (KEY_A),
    .KEY_B (KEY_B)
  ) u_feed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .feed_wr_i (feed_wr),
    .key_i     (reg_wdata_i[KEY_W-1:0]),
    .good_o    (good),
    .bad_o     (bad)
  );

  wdog_prescale #(
    .DIV (PRESCALE)
  ) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (armed),
    .clr_i  (good && en_q),
    .tick_o (tick)
  );

  assign ev = en_q && (expire || bad);

  wdog_down_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (good && en_q),
    .kill_i   (ev),
    .tick_i   (tick),
    .reload_i (reload_q),
    .cnt_o    (cnt),
    .armed_o  (armed),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      mode_q    <= 1'b0;
      irq_q     <= 1'b0;
      wdf_q     <= 1'b0;
      rst_req_q <= 1'b0;
      reload_q  <= MIN_VAL;
    end else begin
      rst_req_q <= ev && mode_q;
      if (load_wr) reload_q <= (reg_wdata_i < MIN_VAL) ? MIN_VAL : reg_wdata_i;
      if (ev) begin
        en_q <= 1'b0;
        if (mode_q) wdf_q <= 1'b1;
        else        irq_q <= 1'b1;
        if (ctrl_wr) mode_q <= reg_wdata_i[C_MODE];
      end else if (ctrl_wr) begin
        en_q   <= en_q | reg_wdata_i[C_EN];
        mode_q <= reg_wdata_i[C_MODE];
        if (!reg_wdata_i[C_IRQ]) irq_q <= 1'b0;
        if (!reg_wdata_i[C_WDF]) wdf_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  reg_rdata_o = CNT_W'({wdf_q, irq_q, mode_q, en_q});
      A_LOAD:  reg_rdata_o = reload_q;
      A_FEED:  reg_rdata_o = '0;
      A_COUNT: reg_rdata_o = cnt;
      default: reg_rdata_o = '0;
    endcase
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/wdog_feed_chk.sv
module wdog_feed_chk #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned MIN_LOAD = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic             en_i,
  input logic             wdf_i,
  input logic             irq_i,
  input logic             armed_i,
  input logic [CNT_W-1:0] reload_i,
  input logic             rst_req_i
);
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> !rst_req_i); // R6
  AST_REQ_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> wdf_i); // R6
  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_i) |-> (rst_req_i || irq_i)); // R2
  AST_RELOAD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i >= CNT_W'(MIN_LOAD)); // R3
  AST_ARMED_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |-> en_i); // R4
  AST_NO_REQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> $past(en_i)); // R9
  AST_FLAG_CLEAR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdf_i) |-> ($past(we_i) && $past(addr_i) == 2'd0 && !$past(wdata_i[3]))); // R10
endmodule

bind wdog_feed_top wdog_feed_chk #(
  .CNT_W    (CNT_W),
  .MIN_LOAD (MIN_LOAD)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (reg_we_i),
  .addr_i    (reg_addr_i),
  .wdata_i   (reg_wdata_i),
  .en_i      (en_q),
  .wdf_i     (wdf_q),
  .irq_i     (irq_q),
  .armed_i   (armed),
  .reload_i  (reload_q),
  .rst_req_i (rst_req_q)
);

// File: tb/wdog_feed_top_tb.sv
module wdog_feed_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req, irq;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  wdog_feed_top u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_re_i    (re),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .rst_req_o   (rst_req),
    .irq_o       (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit m_en, m_mode, m_irq, m_wdf, m_req, m_arm, m_pend;
  longint m_cnt, m_reload;
  int m_pre;

  function automatic longint m_read(logic [1:0] a);
    case (a)
      2'd0: return longint'({m_wdf, m_irq, m_mode, m_en});
      2'd1: return m_reload;
      2'd3: return m_cnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_irq = 0; m_wdf = 0; m_req = 0;
      m_arm = 0; m_pend = 0; m_cnt = 0; m_reload = 256; m_pre = 0;
    end else begin
      bit good, bad, tick, expire, ev, load, old_mode, old_arm;
      longint old_reload;
      good = 0; bad = 0;
      if (we || re) begin
        if (we && addr == 2'd2) begin
          if (m_pend) begin
            if (wdata[7:0] == 8'h55) good = 1; else bad = 1;
            m_pend = 0;
          end else if (wdata[7:0] == 8'hAA) m_pend = 1;
          else bad = 1;
        end else begin
          if (m_pend) bad = 1;
          m_pend = 0;
        end
      end
      tick = m_arm && (m_pre == 3);
      expire = tick && (m_cnt == 1);
      ev = m_en && (expire || bad);
      load = m_en && good;
      old_mode = m_mode; old_arm = m_arm; old_reload = m_reload;
      if (load && !ev) m_cnt = old_reload;
      else if (tick) m_cnt = m_cnt - 1;
      if (ev) m_arm = 0; else if (load) m_arm = 1;
      if (load || !old_arm) m_pre = 0; else m_pre = (m_pre + 1) % 4;
      if (we && addr == 2'd1) m_reload = (wdata < 256) ? 256 : longint'(wdata);
      if (we && addr == 2'd0) begin
        if (!ev) begin
          m_en = m_en | wdata[0];
          if (!wdata[2]) m_irq = 0;
          if (!wdata[3]) m_wdf = 0;
        end
        m_mode = wdata[1];
      end
      if (ev) begin
        m_en = 0;
        if (old_mode) m_wdf = 1; else m_irq = 1;
      end
      m_req = ev && old_mode;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the outputs
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R6 rst_req_o vs model", longint'(rst_req), longint'(m_req));
      chk("R7 irq_o vs model", longint'(irq), longint'(m_irq));
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, string tag);
    @(negedge clk);
    re = 1; addr = a;
    #1;
    chk(tag, longint'(rdata), m_read(a));
    @(negedge clk);
    re = 0;
  endtask

  task automatic feed();
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h55);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    re = 1; addr = 2'd0; #1; chk("R1 ctrl after reset", longint'(rdata), 0);
    addr = 2'd1; #1; chk("R1 reload after reset", longint'(rdata), 256);
    addr = 2'd3; #1; chk("R1 count after reset", longint'(rdata), 0);
    chk("R1 outputs after reset", longint'({rst_req, irq}), 0);
    @(negedge clk); re = 0;

    // R3 clamp
    wr(2'd1, 32'd10);       rd(2'd1, "R3 low reload clamped");
    chk("R3 clamp literal", m_reload, 256);
    wr(2'd1, 32'h12345);    rd(2'd1, "R3 reload stored");
    wr(2'd1, 32'd300);

    // R9 disabled: feeds ignored, bad key ignored
    feed();
    rd(2'd3, "R9 count untouched when disabled");
    wr(2'd2, 32'h33);
    chk("R9 no irq while disabled", longint'({rst_req, irq}), 0);
    rd(2'd0, "R9 ctrl unchanged");

    // R4 enable, counter idle until first feed
    wr(2'd0, 32'h1);
    idle(20);
    rd(2'd3, "R4 count waits for first feed");
    feed();
    rd(2'd3, "R4 count loaded by feed");
    chk("R4 load literal", m_cnt, 300);

    // R2 writing 0 to enable ignored
    wr(2'd0, 32'h0);
    rd(2'd0, "R2 enable stays set");
    chk("R2 enable literal", longint'(m_en), 1);

    idle(100);
    rd(2'd3, "R5 count decrements by prescaled tick");

    // R5/R7 timeout in interrupt mode
    feed();
    begin
      int n = 0;
      while (!irq && n < 5000) begin @(posedge clk); #1; n++; end
      chk("R5 interrupt-mode timeout period", n, 1200);
    end
    rd(2'd0, "R7 irq flag set and enable cleared");
    wr(2'd0, 32'h0);
    rd(2'd0, "R7 irq flag cleared by write 0");
    chk("R7 irq_o low after clear", longint'(irq), 0);

    // R8 broken sequence in reset mode
    wr(2'd0, 32'h3);
    feed();
    wr(2'd2, 32'hAA);
    rd(2'd0, "R8 ctrl before fault");
    chk("R8 foreign access after 0xAA requests reset", longint'(rst_req), 1);
    rd(2'd0, "R6 wdf set, enable cleared");
    chk("R6 wdf literal", longint'(m_wdf), 1);

    // R10 writing 1 keeps flag
    wr(2'd0, 32'hA);
    rd(2'd0, "R10 flag kept on write 1");
    chk("R10 flag literal", longint'(m_wdf), 1);

    // R8 wrong key
    wr(2'd0, 32'hB);
    feed();
    wr(2'd2, 32'h77);
    chk("R8 wrong feed key requests reset", longint'(rst_req), 1);

    // R5/R6 reset-mode timeout, one-cycle pulse
    wr(2'd0, 32'hB);
    feed();
    begin
      int n = 0;
      while (!rst_req && n < 5000) begin @(posedge clk); #1; n++; end
      chk("R5 reset-mode timeout period", n, 1200);
      @(posedge clk); #1;
      chk("R6 reset request lasts one cycle", longint'(rst_req), 0);
    end

    // R10 clear by write 0
    wr(2'd0, 32'h0);
    rd(2'd0, "R10 flag cleared by write 0");

    // R1 hardware reset clears everything
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd999);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(2'd0, "R1 ctrl after second reset");
    rd(2'd1, "R1 reload after second reset");

    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule